// File: doc/BRIEF.md
# Two-Cycle Fault-Masking Plane Evaluator

This block evaluates a programmable single-level logic plane, one output per bitline, while tolerating cells that are stuck in the conducting state. The plane is modelled behaviourally. Each bitline computes NAND, or NOR in the dual mode, of the wordline inputs whose cells are programmed onto it. A stuck cell behaves as an extra operand that was never programmed. Software marks every wordline and every bitline that carries a stuck cell with a fault flag.

When no flag is set, an evaluation takes a single sense cycle. When any flag is set, evaluation splits into two cycles, tracked by a cycle-sequence bit. In the first cycle only unflagged bitlines are sensed, using the true inputs. In the second cycle only flagged bitlines are sensed, and every flagged wordline is forced to the identity value of the gate: 1 for NAND, 0 for NOR. This removes the stuck operand from the term.

A flagged bitline that really uses a flagged wordline loses that operand, so its result cannot be trusted. The block detects this case and raises an uncorrectable flag with the result. Control is a plain start/done pair with no back-pressure. A start is accepted only while the block is idle. The result vector and conflict flag stay valid from done until the next done.

Top module: `fmask_eval`

## Requirements
- R1: After reset, busy, done, conflict and every result bit are 0.
- R2: With mode_nor=0, result bit j equals NOT(AND of in_vec[i] over every wordline i with prog_map[j*NWL+i]=1). A bitline with no programmed cell gives 0.
- R3: With mode_nor=1, result bit j equals NOT(OR of the same operands). A bitline with no programmed cell gives 1, and flagged wordlines are forced to 0 in the second cycle.
- R4: A start sampled high at rising edge N while busy is 0 raises busy from edge N. With no fault flag set, done is high for exactly the cycle after edge N+1 and busy falls at that same edge.
- R5: With any fault flag set, done is high for the cycle after edge N+2, and busy stays high until then.
- R6: In the first cycle of a two-cycle evaluation, flagged bitlines keep their previous result bits while unflagged bitlines are updated at edge N+1. Flagged bitlines are updated at edge N+2.
- R7: When every stuck cell lies on a flagged bitline and a flagged wordline and no conflict exists, the result at done equals the fault-free ideal of R2/R3.
- R8: conflict at done is 1 exactly when some flagged bitline has a programmed cell on a flagged wordline. conflict is held until the next done, and unflagged bitlines remain correct even when it is 1.
- R9: A start raised while busy is 1 is ignored. Timing and result follow the evaluation already running.
- R10: in_vec, mode_nor, wl_flag and bl_flag are captured at the accepting edge, so changes during an evaluation have no effect on its result.
- R11: done is a one-cycle pulse, and the result does not change while busy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an evaluation (accepted when idle) |
| mode_nor | input | 1 | 0: NAND plane, force to 1; 1: NOR plane, force to 0 |
| in_vec | input | NWL | Wordline input vector |
| wl_flag | input | NWL | Per-wordline fault flags |
| bl_flag | input | NBL | Per-bitline fault flags |
| prog_map | input | NBL*NWL | Programmed cells, bit j*NWL+i links wordline i to bitline j |
| stuck_map | input | NBL*NWL | Stuck-conducting cells of the array model, same indexing |
| busy | output | 1 | Evaluation in progress |
| done | output | 1 | One-cycle pulse when result and conflict are valid |
| conflict | output | 1 | Uncorrectable fault pattern in the last evaluation |
| result | output | NBL | Latched bitline results |

## Verification
Counting from the edge N that accepts start, unflagged bitline results appear after edge N+1. In a one-cycle evaluation, done and conflict also appear after N+1. Flagged bitlines, done and conflict appear after N+2 when any flag is set. The bench keeps a behavioural model of this schedule and compares busy, done and result at every falling edge, and conflict whenever done is expected. Directed checks also measure the start-to-done distance, read the held bits one cycle into a two-cycle run, and compare the final vector against the ideal gate values.

// File: rtl/fm_pkg.sv
package fm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2
  } phase_t;
endpackage

// File: rtl/fm_wl_drive.sv
// Wordline drivers: flagged lines take the gate identity in the second cycle.
module fm_wl_drive #(
  parameter int NWL = 8
) (
  input  logic [NWL-1:0] in_q,
  input  logic [NWL-1:0] wl_flag_q,
  input  logic           cyc,
  input  logic           nor_mode,
  output logic [NWL-1:0] wl_eff
);
  for (genvar i = 0; i < NWL; i++) begin : g_wl
    assign wl_eff[i] = (cyc && wl_flag_q[i]) ? ~nor_mode : in_q[i];
  end
endmodule

// File: rtl/fm_plane.sv
// Behavioural plane: each bitline gates the wordlines connected to it.
module fm_plane #(
  parameter int NWL = 8,
  parameter int NBL = 6,
  localparam int CELLS = NWL * NBL
) (
  input  logic [NWL-1:0]   wl_eff,
  input  logic [CELLS-1:0] prog_map,
  input  logic [CELLS-1:0] stuck_map,
  input  logic             nor_mode,
  output logic [NBL-1:0]   bl_val
);
  for (genvar j = 0; j < NBL; j++) begin : g_bl
    logic [NWL-1:0] conn;
    assign conn      = prog_map[j*NWL +: NWL] | stuck_map[j*NWL +: NWL];
    assign bl_val[j] = nor_mode ? ~(|(wl_eff & conn)) : ~(&(wl_eff | ~conn));
  end
endmodule

// File: rtl/fm_sense_gate.sv
// Per-bitline sense enable: the fault flag selects which cycle may sample.
module fm_sense_gate #(
  parameter int NBL = 6
) (
  input  logic [NBL-1:0] bl_flag_q,
  input  logic           cyc,
  input  logic           active,
  output logic [NBL-1:0] sense_en
);
  for (genvar j = 0; j < NBL; j++) begin : g_se
    assign sense_en[j] = active & (bl_flag_q[j] ? cyc : ~cyc);
  end
endmodule

// File: rtl/fm_conflict.sv
// A flagged bitline that uses a flagged wordline cannot be repaired.
module fm_conflict #(
  parameter int NWL = 8,
  parameter int NBL = 6,
  localparam int CELLS = NWL * NBL
) (
  input  logic [CELLS-1:0] prog_map,
  input  logic [NWL-1:0]   wl_flag_q,
  input  logic [NBL-1:0]   bl_flag_q,
  output logic             conflict
);
  logic [NBL-1:0] hit;
  for (genvar j = 0; j < NBL; j++) begin : g_hit
    assign hit[j] = bl_flag_q[j] & (|(prog_map[j*NWL +: NWL] & wl_flag_q));
  end
  assign conflict = |hit;
endmodule

// File: rtl/fmask_eval.sv
module fmask_eval #(
  parameter int NWL = 8,
  parameter int NBL = 6,
  localparam int CELLS = NWL * NBL
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             mode_nor,
  input  logic [NWL-1:0]   in_vec,
  input  logic [NWL-1:0]   wl_flag,
  input  logic [NBL-1:0]   bl_flag,
  input  logic [CELLS-1:0] prog_map,
  input  logic [CELLS-1:0] stuck_map,
  output logic             busy,
  output logic             done,
  output logic             conflict,
  output logic [NBL-1:0]   result
);
  import fm_pkg::*;

  phase_t         phase;
  logic [NWL-1:0] in_q;
  logic [NWL-1:0] wl_flag_q;
  logic [NBL-1:0] bl_flag_q;
  logic           nor_q;
  logic           two_q;
  logic           cyc;
  logic           active;
  logic           first_cyc;
  logic           conf_now;
  logic [NWL-1:0] wl_eff;
  logic [NBL-1:0] bl_val;
  logic [NBL-1:0] sense_en;

  // Cycle-sequence bit: 0 in the first sense cycle, 1 in the second.
  assign cyc       = (phase == ST_SECOND);
  assign active    = (phase != ST_IDLE);
  assign first_cyc = (phase == ST_FIRST);

  fm_wl_drive #(.NWL(NWL)) u_drive (
    .in_q     (in_q),
    .wl_flag_q(wl_flag_q),
    .cyc      (cyc),
    .nor_mode (nor_q),
    .wl_eff   (wl_eff)
  );

  fm_plane #(.NWL(NWL), .NBL(NBL)) u_plane (
    .wl_eff   (wl_eff),
    .prog_map (prog_map),
    .stuck_map(stuck_map),
    .nor_mode (nor_q),
    .bl_val   (bl_val)
  );

  fm_sense_gate #(.NBL(NBL)) u_sense (
    .bl_flag_q(bl_flag_q),
    .cyc      (cyc),
    .active   (active),
    .sense_en (sense_en)
  );

  fm_conflict #(.NWL(NWL), .NBL(NBL)) u_conf (
    .prog_map (prog_map),
    .wl_flag_q(wl_flag_q),
    .bl_flag_q(bl_flag_q),
    .conflict (conf_now)
  );

  // Sequencer and input capture.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= ST_IDLE;
      busy      <= 1'b0;
      done      <= 1'b0;
      conflict  <= 1'b0;
      in_q      <= '0;
      wl_flag_q <= '0;
      bl_flag_q <= '0;
      nor_q     <= 1'b0;
      two_q     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (phase)
        ST_IDLE: begin
          if (start) begin
            in_q      <= in_vec;
            wl_flag_q <= wl_flag;
            bl_flag_q <= bl_flag;
            nor_q     <= mode_nor;
            two_q     <= (|wl_flag) | (|bl_flag);
            busy      <= 1'b1;
            phase     <= ST_FIRST;
          end
        end
        ST_FIRST: begin
          if (two_q) begin
            phase <= ST_SECOND;
          end else begin
            phase    <= ST_IDLE;
            busy     <= 1'b0;
            done     <= 1'b1;
            conflict <= conf_now;
          end
        end
        ST_SECOND: begin
          phase    <= ST_IDLE;
          busy     <= 1'b0;
          done     <= 1'b1;
          conflict <= conf_now;
        end
        default: phase <= ST_IDLE;
      endcase
    end
  end

  // Sense latches: a bitline not enabled this cycle keeps its value.
  for (genvar j = 0; j < NBL; j++) begin : g_lat
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           result[j] <= 1'b0;
      else if (sense_en[j]) result[j] <= bl_val[j];
    end
  end
endmodule

// File: rtl/fmask_eval_chk.sv
module fmask_eval_chk #(
  parameter int NBL = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           busy,
  input logic           done,
  input logic           conflict,
  input logic [NBL-1:0] result,
  input logic [NBL-1:0] bl_flag_q,
  input logic           first_cyc,
  input logic           two_q
);
  assert_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  assert_done_after_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));

  assert_faulty_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (first_cyc && two_q) |=> (((result ^ $past(result)) & bl_flag_q) == '0));

  assert_conflict_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(conflict));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_idle_result_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(result));
endmodule

bind fmask_eval fmask_eval_chk #(.NBL(NBL)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .conflict (conflict),
  .result   (result),
  .bl_flag_q(bl_flag_q),
  .first_cyc(first_cyc),
  .two_q    (two_q)
);

// File: tb/fmask_eval_test.sv
module fmask_eval_test;
  localparam int NWL = 8;
  localparam int NBL = 6;
  localparam int CELLS = NWL * NBL;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic             mode_nor = 1'b0;
  logic [NWL-1:0]   in_vec = '0;
  logic [NWL-1:0]   wl_flag = '0;
  logic [NBL-1:0]   bl_flag = '0;
  logic [CELLS-1:0] prog_map = '0;
  logic [CELLS-1:0] stuck_map = '0;
  logic             busy, done, conflict;
  logic [NBL-1:0]   result;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  fmask_eval #(.NWL(NWL), .NBL(NBL)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_nor(mode_nor),
    .in_vec(in_vec), .wl_flag(wl_flag), .bl_flag(bl_flag),
    .prog_map(prog_map), .stuck_map(stuck_map),
    .busy(busy), .done(done), .conflict(conflict), .result(result)
  );

  always #4 clk = ~clk;  // 125 MHz

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Gate value of bitline j over programmed cells; forced wordlines take the identity.
  function automatic logic gate_eval(int j, logic [NWL-1:0] v, logic [NWL-1:0] wf,
                                     logic nor_m, logic second);
    logic acc = nor_m ? 1'b0 : 1'b1;
    for (int i = 0; i < NWL; i++) begin
      if (prog_map[j*NWL+i]) begin
        logic x = (second && wf[i]) ? ~nor_m : v[i];
        acc = nor_m ? (acc | x) : (acc & x);
      end
    end
    return ~acc;
  endfunction

  function automatic logic conf_calc(logic [NWL-1:0] wf, logic [NBL-1:0] bf);
    for (int j = 0; j < NBL; j++)
      for (int i = 0; i < NWL; i++)
        if (bf[j] && wf[i] && prog_map[j*NWL+i]) return 1'b1;
    return 1'b0;
  endfunction

  // Cycle-by-cycle reference model.
  int             ph = 0;
  logic           e_busy = 0, e_done = 0, e_conf = 0;
  logic [NBL-1:0] e_res = '0;
  logic [NWL-1:0] c_in = '0, c_wf = '0;
  logic [NBL-1:0] c_bf = '0;
  logic           c_nor = 0, c_two = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; e_busy = 0; e_done = 0; e_conf = 0; e_res = '0;
    end else begin
      e_done = 0;
      if (ph == 0) begin
        if (start) begin
          c_in = in_vec; c_wf = wl_flag; c_bf = bl_flag; c_nor = mode_nor;
          c_two = (|wl_flag) || (|bl_flag);
          e_busy = 1; ph = 1;
        end
      end else if (ph == 1) begin
        for (int j = 0; j < NBL; j++)
          if (!c_bf[j]) e_res[j] = gate_eval(j, c_in, c_wf, c_nor, 1'b0);
        if (c_two) ph = 2;
        else begin ph = 0; e_busy = 0; e_done = 1; e_conf = conf_calc(c_wf, c_bf); end
      end else begin
        for (int j = 0; j < NBL; j++)
          if (c_bf[j]) e_res[j] = gate_eval(j, c_in, c_wf, c_nor, 1'b1);
        ph = 0; e_busy = 0; e_done = 1; e_conf = conf_calc(c_wf, c_bf);
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check(c_two ? "R5 busy" : "R4 busy", busy, e_busy);
      check("R11 done", done, e_done);
      check(c_nor ? "R3 result" : "R2 result", result, e_res);
      if (e_done) check("R8 conflict", conflict, e_conf);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected <150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // mid: 0 plain, 1 restart while busy (R9), 2 inputs changed while busy (R10)
  task automatic run_op(input logic [NWL-1:0] v, input logic nor_m,
                        input logic [NWL-1:0] wf, input logic [NBL-1:0] bf, input int mid);
    logic [NBL-1:0] pre = result;
    logic two = (|wf) || (|bf);
    logic ex_conf = conf_calc(wf, bf);
    logic [NBL-1:0] ideal = '0;
    logic [NBL-1:0] goodm = ~bf;
    int lat = 1;
    string tg = (mid == 1) ? "R9" : (mid == 2) ? "R10" : (ex_conf ? "R8" : "R7");
    for (int j = 0; j < NBL; j++) ideal[j] = gate_eval(j, v, wf, nor_m, 1'b0);
    in_vec = v; mode_nor = nor_m; wl_flag = wf; bl_flag = bf; start = 1'b1;
    @(negedge clk); #1;
    start = 1'b0;
    if (mid == 1) begin start = 1'b1; in_vec = ~v; end
    if (mid == 2) begin in_vec = ~v; mode_nor = ~nor_m; wl_flag = ~wf; bl_flag = ~bf; end
    @(negedge clk);
    lat++;
    if (two) begin
      check("R6 held", result & bf, pre & bf);
      check("R6 updated", result & goodm, ideal & goodm);
    end
    #1 start = 1'b0;
    while (!done && lat < 10) begin @(negedge clk); lat++; end
    check(two ? "R5 latency" : "R4 latency", lat, two ? 3 : 2);
    check("R8 conflict", conflict, ex_conf);
    if (!ex_conf) check(tg, result, ideal);
    else check(tg, result & goodm, ideal & goodm);
    @(negedge clk); #1;
    in_vec = v; mode_nor = nor_m; wl_flag = wf; bl_flag = bf;
  endtask

  // Random program with up to three stuck cells; flags marked from their positions.
  task automatic random_trial(input logic nor_m, input int mid);
    logic [NWL-1:0] wf = '0;
    logic [NBL-1:0] bf = '0;
    logic [CELLS-1:0] st = '0;
    int n = $urandom % 4;
    for (int k = 0; k < CELLS; k++) prog_map[k] = (($urandom % 4) == 0);
    for (int k = 0; k < n; k++) begin
      int j = $urandom % NBL;
      int i = $urandom % NWL;
      if (!prog_map[j*NWL+i]) begin st[j*NWL+i] = 1'b1; wf[i] = 1'b1; bf[j] = 1'b1; end
    end
    stuck_map = st;
    run_op(NWL'($urandom), nor_m, wf, bf, mid);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 conflict", conflict, 0);
    check("R1 result", result, 0);
    #1 rst_n = 1'b1;
    @(negedge clk); #1;

    // Empty bitlines: NAND gives 0, NOR gives 1 (R2, R3).
    prog_map = '0; stuck_map = '0;
    run_op(8'hA5, 1'b0, '0, '0, 0);
    run_op(8'hA5, 1'b1, '0, '0, 0);

    // Directed masking: bitline 0 uses wl 0 and 1; stuck cell at bitline 0, wl 5 (R7).
    prog_map = '0; prog_map[0] = 1; prog_map[1] = 1; prog_map[NWL+2] = 1;
    stuck_map = '0; stuck_map[5] = 1;
    run_op(8'h03, 1'b0, 8'h20, 6'h01, 0);
    run_op(8'h23, 1'b0, 8'h20, 6'h01, 0);
    run_op(8'h20, 1'b1, 8'h20, 6'h01, 0);

    // Directed conflict: stuck at bitline 1 wl 0, which bitline 0 really uses (R8).
    stuck_map = '0; stuck_map[5] = 1; stuck_map[NWL+0] = 1;
    run_op(8'h03, 1'b0, 8'h21, 6'h03, 0);
    // Only a wordline flag: still two cycles (R5).
    stuck_map = '0;
    run_op(8'h03, 1'b0, 8'h80, 6'h00, 0);

    // Restart while busy and inputs moving during evaluation (R9, R10).
    stuck_map = '0; stuck_map[5] = 1;
    run_op(8'h03, 1'b0, 8'h20, 6'h01, 1);
    run_op(8'h01, 1'b0, '0, '0, 1);
    run_op(8'h03, 1'b0, 8'h20, 6'h01, 2);
    run_op(8'h02, 1'b1, '0, '0, 2);

    for (int t = 0; t < 300; t++) random_trial(t[0], (t % 7 == 0) ? 1 : (t % 11 == 0) ? 2 : 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule